// File: doc/BRIEF.md
# UART Receive Flow-Control RTS Driver

This block produces the request-to-send level of a UART receiver. A small 16-bit control register holds three bits: a software RTS request, a source select, and a trigger select. With the source select clear, the pin follows the software request. With it set, the pin is driven by the fill state of the receive FIFO. The FIFO occupancy and a programmable level marker arrive on input ports.

The trigger select chooses one of two hardware conditions. With it clear, RTS is asserted while the occupancy equals the level marker. With it set, RTS is asserted while exactly one free slot remains. The pin is active low and comes from a register, so it moves only on a clock edge. There is no hysteresis: RTS deasserts on the first edge after the chosen condition stops holding.

Top module: `uart_rx_rts_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000 and rts_no is 1 (deasserted).
- R2: A write stores bit 12 (software RTS request), bit 8 (trigger select) and bit 7 (source select). The read port returns them at the same positions, and every other bit reads 0.
- R3: Bit 9 is reserved. It reads 0 even after a write of 1.
- R4: With source select 0, rts_no is the inverse of the software RTS request bit.
- R5: With source select 1 and trigger select 0, rts_no is 0 exactly when occupancy equals the level marker. This includes an empty FIFO with a marker of 0, and a full FIFO with a marker equal to the depth.
- R6: With source select 1 and trigger select 1, rts_no is 0 exactly when occupancy equals DEPTH-1. In this case the level marker has no effect.
- R7: In hardware mode, rts_no returns to 1 on the first edge after the selected condition becomes false, with no hysteresis. This covers occupancy one above or below the marker, and a completely full FIFO.
- R8: rts_no is registered. It reflects occupancy one clock edge after the occupancy changes. It reflects a register write two edges after the write edge.
- R9: In hardware mode the software RTS request bit has no effect on rts_no.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 16 | Control register write data |
| rd_data_o | output | 16 | Control register read data |
| occ_i | input | OCC_W | Receive FIFO occupancy, 0 to DEPTH |
| level_i | input | OCC_W | Level marker for the match trigger |
| rts_no | output | 1 | Request-to-send pin, active low |

## Verification
The bench targets the exact-equality boundaries. It tests occupancy one above and one below the marker, a marker of zero on an empty FIFO, and a full FIFO under the one-slot trigger. A design that used a greater-or-equal compare would hold RTS asserted above the marker. A design that used the full count in place of DEPTH-1 would assert one entry late. The bench also writes the reserved bit and the software bit while in hardware mode; a leaking register or mux would show up on the read port or the pin. Latency checks sample the pin just before and just after the relevant edge, which catches a missing or doubled output register.

// File: rtl/uart_rts_pkg.sv
package uart_rts_pkg;
  localparam int unsigned CTRL_W    = 16;
  localparam int unsigned BIT_SWRTS = 12;
  localparam int unsigned BIT_RSV   = 9;
  localparam int unsigned BIT_TSEL  = 8;
  localparam int unsigned BIT_SRC   = 7;

  typedef struct packed {
    logic sw_rts;
    logic tsel;
    logic src;
  } rts_cfg_t;
endpackage

// File: rtl/uart_rts_cfg_reg.sv
module uart_rts_cfg_reg
  import uart_rts_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output rts_cfg_t          cfg_o,
  output logic [CTRL_W-1:0] rd_data_o
);
  rts_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      cfg_q.sw_rts <= wr_data_i[BIT_SWRTS];
      cfg_q.tsel   <= wr_data_i[BIT_TSEL];
      cfg_q.src    <= wr_data_i[BIT_SRC];
    end
  end

  always_comb begin
    rd_data_o            = '0;
    rd_data_o[BIT_SWRTS] = cfg_q.sw_rts;
    rd_data_o[BIT_TSEL]  = cfg_q.tsel;
    rd_data_o[BIT_SRC]   = cfg_q.src;
  end

  assign cfg_o = cfg_q;

  AST_WR_TSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[BIT_TSEL] == $past(wr_data_i[BIT_TSEL])); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o)); // R2
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[BIT_RSV] == 1'b0); // R3
endmodule

// File: rtl/uart_rts_trigger.sv
module uart_rts_trigger #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic [OCC_W-1:0] occ_i,
  input  logic [OCC_W-1:0] level_i,
  input  logic             tsel_i,
  output logic             hit_o
);
  localparam logic [OCC_W-1:0] ONE_LEFT = OCC_W'(DEPTH - 1);

  logic lvl_hit;
  logic slot_hit;

  assign lvl_hit  = (occ_i == level_i);
  assign slot_hit = (occ_i == ONE_LEFT);
  assign hit_o    = tsel_i ? slot_hit : lvl_hit;
endmodule

// File: rtl/uart_rx_rts_ctrl.sv
module uart_rx_rts_ctrl
  import uart_rts_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  input  logic [OCC_W-1:0]  occ_i,
  input  logic [OCC_W-1:0]  level_i,
  output logic              rts_no
);
  rts_cfg_t cfg;
  logic     hw_hit;
  logic     rts_req;

  uart_rts_cfg_reg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .rd_data_o (rd_data_o)
  );

  uart_rts_trigger #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_trig (
    .occ_i   (occ_i),
    .level_i (level_i),
    .tsel_i  (cfg.tsel),
    .hit_o   (hw_hit)
  );

  assign rts_req = cfg.src ? hw_hit : cfg.sw_rts;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rts_no <= 1'b1;
    else         rts_no <= ~rts_req;
  end

  AST_SW_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[BIT_SRC] |=> rts_no == !$past(rd_data_o[BIT_SWRTS])); // R4
  AST_LVL_ASSERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[BIT_SRC] && !rd_data_o[BIT_TSEL] && occ_i == level_i) |=> !rts_no); // R5
  AST_SLOT_ASSERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[BIT_SRC] && rd_data_o[BIT_TSEL] && occ_i == OCC_W'(DEPTH - 1)) |=> !rts_no); // R6
  AST_LVL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[BIT_SRC] && !rd_data_o[BIT_TSEL] && occ_i != level_i) |=> rts_no); // R7
  AST_SLOT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[BIT_SRC] && rd_data_o[BIT_TSEL] && occ_i != OCC_W'(DEPTH - 1)) |=> rts_no); // R7
endmodule

// File: tb/uart_rx_rts_ctrl_test.sv
module uart_rx_rts_ctrl_test;
  localparam int DEPTH = 64;
  localparam int OCC_W = 7;

  typedef struct packed {
    logic [15:0]      ctrl;
    logic [OCC_W-1:0] occ;
    logic [OCC_W-1:0] lvl;
    logic             exp_rts_n;
    logic [3:0]       req;
  } vec_t;

  // ctrl bits: 0x1000 sw request, 0x0100 trigger select, 0x0080 source select
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{16'h0000, 7'd0,  7'd0,  1'b1, 4'd4}, // R4 sw off
    '{16'h1000, 7'd5,  7'd3,  1'b0, 4'd4}, // R4 sw on
    '{16'h1000, 7'd63, 7'd63, 1'b0, 4'd4}, // R4
    '{16'h0080, 7'd10, 7'd10, 1'b0, 4'd5}, // R5 match
    '{16'h0080, 7'd11, 7'd10, 1'b1, 4'd7}, // R7 above marker
    '{16'h0080, 7'd9,  7'd10, 1'b1, 4'd7}, // R7 below marker
    '{16'h1080, 7'd9,  7'd10, 1'b1, 4'd9}, // R9 sw ignored
    '{16'h0180, 7'd63, 7'd10, 1'b0, 4'd6}, // R6 one slot left
    '{16'h0180, 7'd64, 7'd10, 1'b1, 4'd7}, // R7 full
    '{16'h0180, 7'd62, 7'd62, 1'b1, 4'd6}, // R6 marker ignored
    '{16'h0080, 7'd0,  7'd0,  1'b0, 4'd5}, // R5 empty, marker 0
    '{16'h1180, 7'd10, 7'd10, 1'b1, 4'd9}, // R9
    '{16'h0080, 7'd64, 7'd64, 1'b0, 4'd5}  // R5 full, marker = depth
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [15:0]      wr_data_i = '0;
  logic [15:0]      rd_data_o;
  logic [OCC_W-1:0] occ_i = '0;
  logic [OCC_W-1:0] level_i = '0;
  logic             rts_no;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  uart_rx_rts_ctrl #(.DEPTH(DEPTH), .OCC_W(OCC_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .occ_i(occ_i), .level_i(level_i), .rts_no(rts_no)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #7;
    // R1 reset state
    chk("R1 rd", rd_data_o, 16'h0000);
    chk("R1 rts", {15'd0, rts_no}, 16'h0001);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 rts after release", {15'd0, rts_no}, 16'h0001);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      wr_en_i = 1'b1;
      wr_data_i = VEC[i].ctrl;
      occ_i = VEC[i].occ;
      level_i = VEC[i].lvl;
      @(negedge clk_i);
      wr_en_i = 1'b0;
      @(negedge clk_i);
      chk($sformatf("R%0d vec%0d", VEC[i].req, i), {15'd0, rts_no}, {15'd0, VEC[i].exp_rts_n});
    end

    // R2 readback: other bits drop
    wr(16'hFFFF);
    chk("R2 readback", rd_data_o, 16'h1180);
    wr(16'h1000);
    chk("R2 readback sw", rd_data_o, 16'h1000);
    // R3 reserved bit
    wr(16'h0200);
    chk("R3 reserved", rd_data_o, 16'h0000);

    // R8 occupancy latency
    occ_i = 7'd19;
    level_i = 7'd20;
    wr(16'h0080);
    @(negedge clk_i);
    chk("R8 pre", {15'd0, rts_no}, 16'h0001);
    occ_i = 7'd20;
    #1;
    chk("R8 before edge", {15'd0, rts_no}, 16'h0001);
    @(negedge clk_i);
    chk("R8 one edge", {15'd0, rts_no}, 16'h0000);
    occ_i = 7'd21;
    @(negedge clk_i);
    chk("R7 release one edge", {15'd0, rts_no}, 16'h0001);

    // R8 write latency: sw mode, request 1
    wr(16'h0000);
    @(negedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = 16'h1000;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R8 write edge+1", {15'd0, rts_no}, 16'h0001);
    @(negedge clk_i);
    chk("R8 write edge+2", {15'd0, rts_no}, 16'h0000);

    // R1 reset mid-run
    rst_ni = 1'b0;
    #1;
    chk("R1 async rd", rd_data_o, 16'h0000);
    chk("R1 async rts", {15'd0, rts_no}, 16'h0001);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule